// File: doc/BRIEF.md
# Delayed Request-Response Bus Bridge

This block joins an upstream requestor to a downstream responder. It claims requests whose address lies inside one of a set of half-open address windows. Each claimed request is held in an in-order request queue and sent downstream a fixed number of cycles after it was taken. A request that expects an answer also books a place in the response queue when it is taken. Because of that booking, a response coming back from downstream never needs a ready signal. The response is held for the same fixed number of cycles and then offered upstream.

When a claimed request cannot be taken, the bridge drops its accept and raises one internal stall flag. The flag does not say whether the request queue or the response side was the cause. Later the bridge gives the requestor a one-cycle retry pulse, either when a request leaves downstream or when a response is delivered upstream while the request queue has room. The requestor may then present the request again. It can be refused again if the response side is still full.

Both queues keep a timestamp per entry, measured against a shared free-running cycle counter. Only the head entry of a queue can be sent, and only once the counter has reached that entry's timestamp.

Top module: `req_resp_bridge`

## Requirements
- R1: While reset is held and after it is released, dn_req_valid, up_rsp_valid and up_retry are low. Reset discards queued requests, so none is ever forwarded. It also frees every response booking, so RSP_LIMIT response-expecting requests are accepted right after reset.
- R2: A request is claimed only if its address A satisfies base_i <= A < end_i for some window i. For an unclaimed request, up_req_accept stays low, nothing is forwarded downstream, and the stall flag is not set, so no retry follows.
- R3: A request accepted in cycle C (up_req_valid and up_req_accept both high) appears on dn_req_valid/addr/data in cycle C+DELAY. Requests leave in the order they were accepted.
- R4: While REQ_LIMIT requests sit in the request queue, every claimed request is refused (up_req_accept low).
- R5: While RSP_LIMIT responses are booked, a request with up_req_needs_rsp=1 is refused. A request with up_req_needs_rsp=0 is still accepted if the request queue has room. A booking is released when its response is accepted upstream.
- R6: A response presented with dn_rsp_valid in cycle C is always absorbed. It appears on up_rsp_valid/up_rsp_data in cycle C+DELAY, and responses stay in arrival order.
- R7: While dn_req_ready is low, a valid downstream request stays valid with unchanged address and data. While up_rsp_ready is low, a valid upstream response stays valid with unchanged data.
- R8: If the stall flag is set when a request is accepted downstream (dn_req_valid and dn_req_ready high) in cycle C, up_retry is high in cycle C+1 and the flag clears.
- R9: If the stall flag is set when a response is accepted upstream in cycle C, up_retry is high in cycle C+1 only if the request queue held fewer than REQ_LIMIT entries in cycle C. Otherwise the flag stays set.
- R10: up_retry is high only in the cycle after the flag is cleared. A flag cleared at the end of cycle C does not cause another retry in cycle C+2 unless a new refusal happened in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | 1 | Upstream request present |
| up_req_addr | input | ADDR_W | Request address |
| up_req_data | input | DATA_W | Request payload |
| up_req_needs_rsp | input | 1 | Request expects a response |
| up_req_accept | output | 1 | Request taken this cycle |
| up_retry | output | 1 | One-cycle pulse inviting a refused requestor to try again |
| up_rsp_valid | output | 1 | Response offered upstream |
| up_rsp_data | output | DATA_W | Response payload |
| up_rsp_ready | input | 1 | Upstream takes the response |
| dn_req_valid | output | 1 | Request offered downstream |
| dn_req_addr | output | ADDR_W | Forwarded address |
| dn_req_data | output | DATA_W | Forwarded payload |
| dn_req_needs_rsp | output | 1 | Forwarded request expects a response |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_rsp_valid | input | 1 | Response from downstream, always absorbed |
| dn_rsp_data | input | DATA_W | Response payload |

## Verification
The bench builds the bridge with REQ_LIMIT=3, RSP_LIMIT=2 and DELAY=4, using windows 0x1000-0x1FFF and 0x8000-0x80FF. These small limits let a handful of requests fill the request queue or use up every response booking. The bench can then reach both stall causes, and also the case where both hold at once. A delay of 4 leaves enough idle cycles to confirm that outputs stay quiet before they are due. It also lets a response become deliverable while the request queue is still full and blocked downstream, which is the one case where a pending retry has to wait.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int TS_W   = 16;

    typedef logic [TS_W-1:0] ts_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              needs_rsp;
    } req_t;

    typedef logic [DATA_W-1:0] rsp_t;

    // True once 'now' has reached 'due', tolerant of counter wrap
    // as long as the gap stays below half the counter range.
    function automatic logic due_reached(ts_t now, ts_t due);
        ts_t diff;
        diff = now - due;
        return ~diff[TS_W-1];
    endfunction

    function automatic ts_t due_after(ts_t now, int unsigned dly);
        return now + ts_t'(dly);
    endfunction

endpackage

// File: rtl/addr_window_match.sv
module addr_window_match #(
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*bridge_pkg::ADDR_W-1:0] BASES = '0,
    parameter logic [NUM_WIN*bridge_pkg::ADDR_W-1:0] ENDS  = '0
) (
    input  logic [bridge_pkg::ADDR_W-1:0] addr,
    output logic                          hit
);
    localparam int AW = bridge_pkg::ADDR_W;

    logic [NUM_WIN-1:0] in_win;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign in_win[g] = (addr >= BASES[g*AW +: AW]) && (addr < ENDS[g*AW +: AW]);
    end

    assign hit = |in_win;

endmodule

// File: rtl/timed_fifo.sv
module timed_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int DELAY = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bridge_pkg::ts_t               now,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop,
    output logic                          head_valid,
    output logic [WIDTH-1:0]              head_data,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    import bridge_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    ts_t              due   [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             full, push_ok, pop_ok;

    function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (count == CW'(DEPTH));
    assign head_valid = (count != '0) && due_reached(now, due[rd_ptr]);
    assign head_data  = store[rd_ptr];
    assign push_ok    = push && !full;
    assign pop_ok     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= push_data;
            due[wr_ptr]   <= due_after(now, DELAY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= next_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (!push_ok && pop_ok) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/req_resp_bridge.sv
module req_resp_bridge #(
    parameter int REQ_LIMIT = 4,
    parameter int RSP_LIMIT = 2,
    parameter int DELAY     = 3,
    parameter int NUM_WIN   = 2,
    parameter logic [NUM_WIN*bridge_pkg::ADDR_W-1:0] WIN_BASE = {16'h8000, 16'h1000},
    parameter logic [NUM_WIN*bridge_pkg::ADDR_W-1:0] WIN_END  = {16'h8100, 16'h2000}
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          up_req_valid,
    input  logic [bridge_pkg::ADDR_W-1:0] up_req_addr,
    input  logic [bridge_pkg::DATA_W-1:0] up_req_data,
    input  logic                          up_req_needs_rsp,
    output logic                          up_req_accept,
    output logic                          up_retry,
    output logic                          up_rsp_valid,
    output logic [bridge_pkg::DATA_W-1:0] up_rsp_data,
    input  logic                          up_rsp_ready,
    output logic                          dn_req_valid,
    output logic [bridge_pkg::ADDR_W-1:0] dn_req_addr,
    output logic [bridge_pkg::DATA_W-1:0] dn_req_data,
    output logic                          dn_req_needs_rsp,
    input  logic                          dn_req_ready,
    input  logic                          dn_rsp_valid,
    input  logic [bridge_pkg::DATA_W-1:0] dn_rsp_data
);
    import bridge_pkg::*;

    localparam int QW = $clog2(REQ_LIMIT + 1);
    localparam int OW = $clog2(RSP_LIMIT + 1);

    ts_t           now_q;
    logic          win_hit;
    logic [QW-1:0] req_count;
    logic [OW-1:0] rsp_count;
    logic [OW-1:0] outstanding_q;
    logic          req_full, rsp_full;
    logic          refuse, req_pop, rsp_pop, retry_fire;
    logic          retry_pending_q;
    req_t          req_in, req_head;
    rsp_t          rsp_head;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    addr_window_match #(
        .NUM_WIN (NUM_WIN),
        .BASES   (WIN_BASE),
        .ENDS    (WIN_END)
    ) u_decode (
        .addr (up_req_addr),
        .hit  (win_hit)
    );

    assign req_full = (req_count == QW'(REQ_LIMIT));
    assign rsp_full = (outstanding_q == OW'(RSP_LIMIT));

    assign up_req_accept = up_req_valid && win_hit && !req_full
                           && !(up_req_needs_rsp && rsp_full);
    assign refuse        = up_req_valid && win_hit && !up_req_accept;

    assign req_in.addr      = up_req_addr;
    assign req_in.data      = up_req_data;
    assign req_in.needs_rsp = up_req_needs_rsp;

    timed_fifo #(
        .DEPTH (REQ_LIMIT),
        .WIDTH ($bits(req_t)),
        .DELAY (DELAY)
    ) u_req_q (
        .clk        (clk),
        .rst        (rst),
        .now        (now_q),
        .push       (up_req_accept),
        .push_data  (req_in),
        .pop        (req_pop),
        .head_valid (dn_req_valid),
        .head_data  (req_head),
        .count      (req_count)
    );

    assign req_pop          = dn_req_valid && dn_req_ready;
    assign dn_req_addr      = req_head.addr;
    assign dn_req_data      = req_head.data;
    assign dn_req_needs_rsp = req_head.needs_rsp;

    timed_fifo #(
        .DEPTH (RSP_LIMIT),
        .WIDTH ($bits(rsp_t)),
        .DELAY (DELAY)
    ) u_rsp_q (
        .clk        (clk),
        .rst        (rst),
        .now        (now_q),
        .push       (dn_rsp_valid),
        .push_data  (dn_rsp_data),
        .pop        (rsp_pop),
        .head_valid (up_rsp_valid),
        .head_data  (rsp_head),
        .count      (rsp_count)
    );

    assign rsp_pop     = up_rsp_valid && up_rsp_ready;
    assign up_rsp_data = rsp_head;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= '0;
        end else begin
            if ((up_req_accept && up_req_needs_rsp) && !rsp_pop)
                outstanding_q <= outstanding_q + 1'b1;
            else if (!(up_req_accept && up_req_needs_rsp) && rsp_pop)
                outstanding_q <= outstanding_q - 1'b1;
        end
    end

    assign retry_fire = retry_pending_q && (req_pop || (rsp_pop && !req_full));

    always_ff @(posedge clk) begin
        if (rst) begin
            retry_pending_q <= 1'b0;
            up_retry        <= 1'b0;
        end else begin
            retry_pending_q <= refuse || (retry_pending_q && !retry_fire);
            up_retry        <= retry_fire;
        end
    end

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int REQ_LIMIT = 4,
    parameter int RSP_LIMIT = 2,
    parameter int QW = 3,
    parameter int OW = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          up_req_valid,
    input logic                          up_req_accept,
    input logic                          win_hit,
    input logic                          up_retry,
    input logic                          retry_pending,
    input logic                          up_rsp_valid,
    input logic                          up_rsp_ready,
    input logic [bridge_pkg::DATA_W-1:0] up_rsp_data,
    input logic                          dn_req_valid,
    input logic                          dn_req_ready,
    input logic [bridge_pkg::ADDR_W-1:0] dn_req_addr,
    input logic [bridge_pkg::DATA_W-1:0] dn_req_data,
    input logic [QW-1:0]                 req_count,
    input logic [OW-1:0]                 rsp_count,
    input logic [OW-1:0]                 outstanding
);

    AST_OUTSTANDING_BOUND: assert property (@(posedge clk) disable iff (rst)
        outstanding <= OW'(RSP_LIMIT)); // R5

    AST_RSP_SPACE: assert property (@(posedge clk) disable iff (rst)
        rsp_count <= outstanding); // R6

    AST_ACCEPT_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        up_req_accept |-> (up_req_valid && win_hit)); // R2

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (req_count == QW'(REQ_LIMIT)) |-> !up_req_accept); // R4

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && !dn_req_ready) |=>
            (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_data))); // R7

    AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_data))); // R7

    AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(up_retry) |-> $past(retry_pending)); // R10

endmodule

bind req_resp_bridge bridge_checker #(
    .REQ_LIMIT (REQ_LIMIT),
    .RSP_LIMIT (RSP_LIMIT),
    .QW        ($clog2(REQ_LIMIT + 1)),
    .OW        ($clog2(RSP_LIMIT + 1))
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .up_req_valid  (up_req_valid),
    .up_req_accept (up_req_accept),
    .win_hit       (win_hit),
    .up_retry      (up_retry),
    .retry_pending (retry_pending_q),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_ready  (up_rsp_ready),
    .up_rsp_data   (up_rsp_data),
    .dn_req_valid  (dn_req_valid),
    .dn_req_ready  (dn_req_ready),
    .dn_req_addr   (dn_req_addr),
    .dn_req_data   (dn_req_data),
    .req_count     (req_count),
    .rsp_count     (rsp_count),
    .outstanding   (outstanding_q)
);

// File: tb/sim_req_resp_bridge.sv
module sim_req_resp_bridge;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_req_valid = 1'b0;
    logic [15:0] up_req_addr = '0;
    logic [15:0] up_req_data = '0;
    logic        up_req_needs_rsp = 1'b0;
    logic        up_req_accept, up_retry, up_rsp_valid;
    logic [15:0] up_rsp_data;
    logic        up_rsp_ready = 1'b1;
    logic        dn_req_valid, dn_req_needs_rsp;
    logic [15:0] dn_req_addr, dn_req_data;
    logic        dn_req_ready = 1'b1;
    logic        dn_rsp_valid = 1'b0;
    logic [15:0] dn_rsp_data = '0;

    logic        nx_rst = 1'b1, nx_rv = 1'b0, nx_rn = 1'b0;
    logic [15:0] nx_ra = '0, nx_rd = '0, nx_pd = '0;
    logic        nx_dready = 1'b1, nx_uready = 1'b1, nx_pv = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    req_resp_bridge #(
        .REQ_LIMIT (3),
        .RSP_LIMIT (2),
        .DELAY     (4),
        .NUM_WIN   (2),
        .WIN_BASE  ({16'h8000, 16'h1000}),
        .WIN_END   ({16'h8100, 16'h2000})
    ) u0 (
        .clk              (clk),
        .rst              (rst),
        .up_req_valid     (up_req_valid),
        .up_req_addr      (up_req_addr),
        .up_req_data      (up_req_data),
        .up_req_needs_rsp (up_req_needs_rsp),
        .up_req_accept    (up_req_accept),
        .up_retry         (up_retry),
        .up_rsp_valid     (up_rsp_valid),
        .up_rsp_data      (up_rsp_data),
        .up_rsp_ready     (up_rsp_ready),
        .dn_req_valid     (dn_req_valid),
        .dn_req_addr      (dn_req_addr),
        .dn_req_data      (dn_req_data),
        .dn_req_needs_rsp (dn_req_needs_rsp),
        .dn_req_ready     (dn_req_ready),
        .dn_rsp_valid     (dn_rsp_valid),
        .dn_rsp_data      (dn_rsp_data)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: apply staged inputs at the falling edge, then settle.
    task automatic cyc();
        @(negedge clk);
        rst              = nx_rst;
        up_req_valid     = nx_rv;
        up_req_addr      = nx_ra;
        up_req_data      = nx_rd;
        up_req_needs_rsp = nx_rn;
        dn_req_ready     = nx_dready;
        up_rsp_ready     = nx_uready;
        dn_rsp_valid     = nx_pv;
        dn_rsp_data      = nx_pd;
        #1;
    endtask

    task automatic put_req(logic [15:0] a, logic [15:0] d, logic n, int exp_acc, string tag);
        nx_rv = 1'b1; nx_ra = a; nx_rd = d; nx_rn = n;
        cyc();
        chk(tag, up_req_accept, exp_acc);
        nx_rv = 1'b0;
    endtask

    task automatic put_rsp(logic [15:0] d);
        nx_pv = 1'b1; nx_pd = d;
        cyc();
        nx_pv = 1'b0;
    endtask

    task automatic t_reset();
        cyc(); cyc();
        chk("R1 dn valid in reset", dn_req_valid, 0);
        chk("R1 up rsp valid in reset", up_rsp_valid, 0);
        nx_rst = 1'b0;
        cyc();
        chk("R1 retry after reset", up_retry, 0);
        chk("R1 dn valid after reset", dn_req_valid, 0);
    endtask

    task automatic t_latency();
        put_req(16'h1004, 16'h00A1, 1'b0, 1, "R3 accept X");   // c0
        put_req(16'h1FFF, 16'h00B2, 1'b0, 1, "R3 accept Y");   // c1
        cyc(); chk("R3 not yet c2", dn_req_valid, 0);
        chk("R10 no retry c2", up_retry, 0);
        cyc(); chk("R3 not yet c3", dn_req_valid, 0);
        cyc(); chk("R3 X valid c4", dn_req_valid, 1);
        chk("R3 X addr", dn_req_addr, 16'h1004);
        chk("R3 X data", dn_req_data, 16'h00A1);
        cyc(); chk("R3 Y valid c5", dn_req_valid, 1);
        chk("R3 Y addr order", dn_req_addr, 16'h1FFF);
        cyc(); chk("R3 drained c6", dn_req_valid, 0);
        chk("R10 no retry c6", up_retry, 0);
    endtask

    task automatic t_window();
        put_req(16'h3000, 16'h0001, 1'b0, 0, "R2 outside refused");     // c0
        put_req(16'h2000, 16'h0002, 1'b0, 0, "R2 end exclusive");       // c1
        put_req(16'h80FF, 16'h0003, 1'b0, 1, "R2 second window last");  // c2
        cyc(); chk("R2 nothing forwarded c3", dn_req_valid, 0);
        cyc(); cyc();
        cyc(); chk("R2 claimed one c6", dn_req_valid, 1);
        chk("R2 claimed addr", dn_req_addr, 16'h80FF);
        cyc(); chk("R2 no retry from unclaimed", up_retry, 0);
        chk("R2 only one forwarded", dn_req_valid, 0);
    endtask

    task automatic t_req_full();
        nx_dready = 1'b0;
        put_req(16'h1100, 16'h0010, 1'b0, 1, "R4 fill 0");  // c0
        put_req(16'h1104, 16'h0011, 1'b0, 1, "R4 fill 1");  // c1
        put_req(16'h1108, 16'h0012, 1'b0, 1, "R4 fill 2");  // c2
        put_req(16'h110C, 16'h0013, 1'b0, 0, "R4 full refuse"); // c3
        cyc(); chk("R7 head valid c4", dn_req_valid, 1);   // c4
        cyc(); chk("R7 head held c5", dn_req_valid, 1);
        chk("R7 head addr c5", dn_req_addr, 16'h1100);
        cyc(); chk("R7 head data c6", dn_req_data, 16'h0010);
        chk("R8 no retry while blocked", up_retry, 0);
        nx_dready = 1'b1;
        cyc(); chk("R8 pop c7", dn_req_valid, 1);            // c7
        cyc(); chk("R8 retry after dn pop", up_retry, 1);    // c8
        chk("R3 order entry 1", dn_req_addr, 16'h1104);
        cyc(); chk("R10 single pulse", up_retry, 0);         // c9
        chk("R3 order entry 2", dn_req_addr, 16'h1108);
        cyc(); chk("R4 drained", dn_req_valid, 0);           // c10
    endtask

    task automatic t_rsp_full();
        put_req(16'h1010, 16'h00A0, 1'b1, 1, "R5 book A");       // c0
        put_req(16'h1014, 16'h00B0, 1'b1, 1, "R5 book B");       // c1
        put_req(16'h1018, 16'h00C0, 1'b0, 1, "R5 no-rsp passes"); // c2
        put_req(16'h101C, 16'h00D0, 1'b1, 0, "R5 bookings full"); // c3
        cyc(); chk("R3 A out c4", dn_req_addr, 16'h1010);         // c4
        chk("R3 A needs rsp", dn_req_needs_rsp, 1);
        cyc(); chk("R8 retry c5", up_retry, 1);                   // c5
        cyc(); chk("R10 no retry c6", up_retry, 0);               // c6
        put_req(16'h101C, 16'h00D0, 1'b1, 0, "R5 retried refused"); // c7
        put_rsp(16'h005A);                                        // c8
        put_rsp(16'h005B);                                        // c9
        cyc(); chk("R6 not yet c10", up_rsp_valid, 0);
        cyc(); chk("R6 not yet c11", up_rsp_valid, 0);
        chk("R9 no early retry", up_retry, 0);
        cyc(); chk("R6 rsp valid c12", up_rsp_valid, 1);          // c12
        chk("R6 rsp data 5A", up_rsp_data, 16'h005A);
        cyc(); chk("R9 retry after rsp", up_retry, 1);            // c13
        chk("R6 rsp data 5B", up_rsp_data, 16'h005B);
        put_req(16'h101C, 16'h00D0, 1'b1, 1, "R5 booking freed"); // c14
        chk("R10 no second retry", up_retry, 0);
        chk("R6 drained", up_rsp_valid, 0);
        cyc(); cyc(); cyc();
        cyc(); chk("R3 D out c18", dn_req_addr, 16'h101C);        // c18
        put_rsp(16'h005C);                                        // c19
        chk("R10 no retry without refusal", up_retry, 0);
        cyc(); cyc(); cyc();
        cyc(); chk("R6 D rsp c23", up_rsp_data, 16'h005C);        // c23
        chk("R6 D rsp valid", up_rsp_valid, 1);
        cyc();
    endtask

    task automatic t_retry_blocked();
        put_req(16'h8000, 16'h00E0, 1'b1, 1, "R9 book E");        // c0
        cyc(); cyc(); cyc();
        cyc(); chk("R3 E out c4", dn_req_addr, 16'h8000);         // c4
        nx_dready = 1'b0; nx_uready = 1'b0;
        put_req(16'h8010, 16'h00F0, 1'b0, 1, "R4 F0");            // c5
        put_req(16'h8014, 16'h00F1, 1'b0, 1, "R4 F1");            // c6
        put_req(16'h8018, 16'h00F2, 1'b0, 1, "R4 F2");            // c7
        nx_pv = 1'b1; nx_pd = 16'h0077;
        put_req(16'h801C, 16'h00F3, 1'b0, 0, "R4 G refused");     // c8
        nx_pv = 1'b0;
        cyc(); cyc(); cyc();                                      // c9..c11
        cyc(); chk("R7 rsp held c12", up_rsp_valid, 1);           // c12
        chk("R6 rsp data 77", up_rsp_data, 16'h0077);
        cyc(); chk("R7 rsp still c13", up_rsp_valid, 1);          // c13
        chk("R7 rsp data stable", up_rsp_data, 16'h0077);
        nx_uready = 1'b1;
        cyc();                                                    // c14
        nx_dready = 1'b1;
        cyc(); chk("R9 no retry, queue full", up_retry, 0);       // c15
        chk("R7 dn head F0", dn_req_addr, 16'h8010);
        cyc(); chk("R8 retry after F0 leaves", up_retry, 1);      // c16
        chk("R6 rsp consumed", up_rsp_valid, 0);
        cyc(); cyc(); cyc();
        chk("R3 queue drained", dn_req_valid, 0);
    endtask

    task automatic t_midreset();
        put_req(16'h1200, 16'h0099, 1'b1, 1, "R1 load before reset");
        nx_rst = 1'b1;
        cyc(); cyc();
        nx_rst = 1'b0;
        cyc(); cyc(); cyc(); cyc(); cyc();
        chk("R1 discarded request", dn_req_valid, 0);
        put_req(16'h1204, 16'h0001, 1'b1, 1, "R1 booking 1 free");
        put_req(16'h1208, 16'h0002, 1'b1, 1, "R1 booking 2 free");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_window();
        t_req_full();
        t_rsp_full();
        t_retry_blocked();
        t_midreset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule